// File: doc/BRIEF.md
# Unsigned 8x8 Multiplier with 4-2 Compressor Reduction

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product with no clock and no register anywhere in the path. The product is ready in the same cycle the operands arrive. The design has four parts: a partial-product generator, a three-stage reduction tree, a 4-2 compressor cell and a final carry-propagate adder. The generator forms eight shifted AND rows.

The reduction tree lowers the row count from eight to six, then to four, then to two. The first stage uses two rows of full adders. The second and third stages each use one row of 4-2 compressors. A 4-2 compressor takes four bits of equal weight plus a carry-in. It returns a sum bit of the same weight and two bits of double weight. Its lateral carry-out depends only on three of its inputs and never on its carry-in. That lateral carry-out feeds the carry-in of the next column up in the same row, so a lateral carry moves at most one column. A ripple adder sums the last two rows.

Top module: `wmul_c42`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals `opa * opb` as a 16-bit unsigned value.
- R2: When either operand is 0, `prod` is 0.
- R3: With both operands at 255, `prod` is 65025 (0xFE01), the largest product.
- R4: For all 32 combinations of its five input bits, the compressor cell satisfies x1+x2+x3+x4+cin = sum + 2*(carry+cout).
- R5: The compressor cell's `cout` is the majority of x1, x2 and x3. Toggling `cin` with the other inputs held never changes `cout`.
- R6: Within a compressor row, each column's `cout` feeds the next column's `cin`, and column 0 takes a carry-in of 0. Operands that cause long carry runs, such as 0xFF times 0x81 (32895) and 0xFF times 0xFF, still give exact products.
- R7: Multiplying by 1 returns the other operand unchanged. Multiplying by 2^k returns the other operand shifted left by k.
- R8: The block is purely combinational. A new operand pair shows its product before the next clock edge, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Multiplicand, unsigned |
| opb | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product of opa and opb |

## Verification
A compressor that lets `cout` follow `cin` would still give correct arithmetic. Only the cell-level check that toggles `cin` alone catches it, so the bench compares `cout` across both `cin` values for every other input pattern. Several errors show up only on carry-heavy operands such as all-ones values and 0x81: a broken lateral carry link, a nonzero carry-in at column 0, or a carry that is dropped or misplaced. These give products that are wrong by a power of two. Powers-of-two operands expose partial-product rows that are shifted by the wrong amount. The zero and maximum operands expose rows that are gated wrongly and losses in the top bits. A final sweep of all 65536 operand pairs leaves no input pattern unchecked.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
   // Majority of three bits; used for carries that must not depend on cin
   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction
endpackage

// File: rtl/wmul_cmp42.sv
module wmul_cmp42
   import wmul_pkg::*;
(
   input  logic x1,
   input  logic x2,
   input  logic x3,
   input  logic x4,
   input  logic cin,
   output logic sum,
   output logic carry,
   output logic cout
);
   logic s_mid;

   // first level: three bits into a partial sum and the lateral carry
   assign s_mid = x1 ^ x2 ^ x3;
   assign cout  = maj3(x1, x2, x3);
   // second level: partial sum, fourth bit and the incoming lateral carry
   assign sum   = s_mid ^ x4 ^ cin;
   assign carry = maj3(s_mid, x4, cin);

   always_comb begin
      a_r4_cell_weight: assert (({2'b0, x1} + {2'b0, x2} + {2'b0, x3} + {2'b0, x4} + {2'b0, cin})
                                == ({2'b0, sum} + {1'b0, carry, 1'b0} + {1'b0, cout, 1'b0}))
         else $error("compressor weight mismatch");
   end
endmodule

// File: rtl/wmul_cmp42_row.sv
module wmul_cmp42_row #(
   parameter int N = 16
) (
   input  logic [N-1:0] ra,
   input  logic [N-1:0] rb,
   input  logic [N-1:0] rc,
   input  logic [N-1:0] rd,
   output logic [N-1:0] rsum,
   output logic [N-1:0] rcar
);
   localparam int XW = N + 2;

   logic [N:0]   lat;      // lateral carries between neighbouring columns
   logic [N-1:0] car_raw;  // carry outputs at their own column

   if (N < 2) begin : g_bad_width
      $error("compressor row needs at least two columns");
   end

   assign lat[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_col
      wmul_cmp42 u_cell (
         .x1   (ra[i]),
         .x2   (rb[i]),
         .x3   (rc[i]),
         .x4   (rd[i]),
         .cin  (lat[i]),
         .sum  (rsum[i]),
         .carry(car_raw[i]),
         .cout (lat[i+1])
      );
   end

   assign rcar = {car_raw[N-2:0], 1'b0};

   always_comb begin
      a_r6_row_exact: assert ((XW'(ra) + XW'(rb) + XW'(rc) + XW'(rd))
                              == (XW'(rsum) + (XW'(car_raw) << 1) + (XW'(lat[N]) << N)))
         else $error("4-2 row lost weight");
   end
endmodule

// File: rtl/wmul_csa_row.sv
module wmul_csa_row
   import wmul_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] rx,
   input  logic [N-1:0] ry,
   input  logic [N-1:0] rz,
   output logic [N-1:0] rsum,
   output logic [N-1:0] rcar
);
   localparam int XW = N + 2;

   logic [N-1:0] car_raw;

   for (genvar i = 0; i < N; i++) begin : g_fa
      assign rsum[i]    = rx[i] ^ ry[i] ^ rz[i];
      assign car_raw[i] = maj3(rx[i], ry[i], rz[i]);
   end

   assign rcar = {car_raw[N-2:0], 1'b0};

   always_comb begin
      a_r1_csa_exact: assert ((XW'(rx) + XW'(ry) + XW'(rz))
                              == (XW'(rsum) + (XW'(car_raw) << 1)))
         else $error("full-adder row lost weight");
   end
endmodule

// File: rtl/wmul_ppgen.sv
module wmul_ppgen #(
   parameter int W = 8
) (
   input  logic [W-1:0]          mcand,
   input  logic [W-1:0]          mplier,
   output logic [W-1:0][2*W-1:0] pp
);
   localparam int PW = 2 * W;

   for (genvar r = 0; r < W; r++) begin : g_row
      assign pp[r] = PW'(mcand & {W{mplier[r]}}) << r;
   end
endmodule

// File: rtl/wmul_tree.sv
module wmul_tree #(
   parameter int W = 8
) (
   input  logic [W-1:0][2*W-1:0] pp,
   output logic [2*W-1:0]        fin_a,
   output logic [2*W-1:0]        fin_b
);
   localparam int PW = 2 * W;
   localparam int XW = PW + 4;

   if (W != 8) begin : g_bad_rows
      $error("reduction tree is laid out for exactly eight rows");
   end

   // stage 1: heights 8 -> 6 with two full-adder rows
   logic [PW-1:0] s1a, c1a, s1b, c1b;
   wmul_csa_row #(.N(PW)) u_st1_a (.rx(pp[0]), .ry(pp[1]), .rz(pp[2]), .rsum(s1a), .rcar(c1a));
   wmul_csa_row #(.N(PW)) u_st1_b (.rx(pp[3]), .ry(pp[4]), .rz(pp[5]), .rsum(s1b), .rcar(c1b));

   // stage 2: heights 6 -> 4 with one compressor row
   logic [PW-1:0] s2, c2;
   wmul_cmp42_row #(.N(PW)) u_st2 (
      .ra(s1a), .rb(c1a), .rc(s1b), .rd(c1b), .rsum(s2), .rcar(c2)
   );

   // stage 3: heights 4 -> 2 with one compressor row
   wmul_cmp42_row #(.N(PW)) u_st3 (
      .ra(s2), .rb(c2), .rc(pp[6]), .rd(pp[7]), .rsum(fin_a), .rcar(fin_b)
   );

   logic [PW-1:0] pp_total;
   always_comb begin
      pp_total = '0;
      for (int r = 0; r < W; r++) pp_total = pp_total + pp[r];
      a_r1_tree_keeps_value: assert (PW'(XW'(fin_a) + XW'(fin_b)) == pp_total)
         else $error("reduction tree changed the value");
   end
endmodule

// File: rtl/wmul_cpa.sv
module wmul_cpa
   import wmul_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] xa,
   input  logic [N-1:0] xb,
   output logic [N-1:0] total
);
   logic [N:0] cy;

   assign cy[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign total[i] = xa[i] ^ xb[i] ^ cy[i];
      assign cy[i+1]  = maj3(xa[i], xb[i], cy[i]);
   end

   always_comb begin
      a_r1_cpa_sum: assert (((N+1)'(xa) + (N+1)'(xb)) == {cy[N], total})
         else $error("carry-propagate adder mismatch");
   end
endmodule

// File: rtl/wmul_c42.sv
module wmul_c42 #(
   parameter int W = 8
) (
   input  logic [W-1:0]   opa,
   input  logic [W-1:0]   opb,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   if (W != 8) begin : g_bad_w
      $error("operand width must be 8");
   end

   logic [W-1:0][PW-1:0] pp;
   logic [PW-1:0]        row_a, row_b;

   wmul_ppgen #(.W(W)) u_pp (.mcand(opa), .mplier(opb), .pp(pp));
   wmul_tree  #(.W(W)) u_tree (.pp(pp), .fin_a(row_a), .fin_b(row_b));
   wmul_cpa   #(.N(PW)) u_cpa (.xa(row_a), .xb(row_b), .total(prod));

   always_comb begin
      a_r1_product: assert ((PW'(opa) * PW'(opb)) == prod)
         else $error("product mismatch");
      a_r2_zero: assert (!((opa == '0) || (opb == '0)) || (prod == '0))
         else $error("zero operand gave nonzero product");
   end
endmodule

// File: tb/wmul_c42_tb.sv
module wmul_c42_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  opa, opb;
   logic [15:0] prod;

   wmul_c42 #(.W(8)) u_dut (.opa(opa), .opb(opb), .prod(prod));

   logic cx1, cx2, cx3, cx4, ccin, csum, ccar, ccout;
   wmul_cmp42 u_cell (.x1(cx1), .x2(cx2), .x3(cx3), .x4(cx4), .cin(ccin),
                      .sum(csum), .carry(ccar), .cout(ccout));

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // drive after a rising edge, sample at the falling edge
   task automatic apply(input int a, input int b);
      @(posedge clk);
      opa = 8'(a);
      opb = 8'(b);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      apply(0, 0);
      chk("R2 reset-state product", int'(prod), 0);
   endtask

   task automatic t_cell();
      for (int v = 0; v < 16; v++) begin
         int c0;
         {cx1, cx2, cx3, cx4} = 4'(v);
         ccin = 1'b0;
         #1;
         c0 = int'(ccout);
         chk("R4 cell weight cin=0", int'(csum) + 2 * (int'(ccar) + int'(ccout)),
             int'(cx1) + int'(cx2) + int'(cx3) + int'(cx4));
         ccin = 1'b1;
         #1;
         chk("R4 cell weight cin=1", int'(csum) + 2 * (int'(ccar) + int'(ccout)),
             int'(cx1) + int'(cx2) + int'(cx3) + int'(cx4) + 1);
         chk("R5 cout independent of cin", int'(ccout), c0);
         chk("R5 cout is majority", int'(ccout),
             (int'(cx1) + int'(cx2) + int'(cx3) >= 2) ? 1 : 0);
      end
   endtask

   task automatic t_zero();
      for (int k = 0; k < 256; k += 37) begin
         apply(k, 0);
         chk("R2 b zero", int'(prod), 0);
         apply(0, k);
         chk("R2 a zero", int'(prod), 0);
      end
   endtask

   task automatic t_max();
      apply(255, 255);
      chk("R3 max product", int'(prod), 65025);
   endtask

   task automatic t_carry_runs();
      apply(8'hFF, 8'h81);
      chk("R6 0xFF*0x81", int'(prod), 32895);
      apply(8'h81, 8'hFF);
      chk("R6 0x81*0xFF", int'(prod), 32895);
      apply(8'hFE, 8'hFF);
      chk("R6 0xFE*0xFF", int'(prod), 64770);
      apply(8'h7F, 8'h7F);
      chk("R6 0x7F*0x7F", int'(prod), 16129);
   endtask

   task automatic t_identity_shift();
      for (int k = 0; k < 8; k++) begin
         apply(8'hB5, 1 << k);
         chk("R7 shift by power of two", int'(prod), 32'hB5 << k);
      end
      apply(1, 8'hC3);
      chk("R7 one times x", int'(prod), 8'hC3);
   endtask

   task automatic t_same_cycle();
      @(posedge clk);
      opa = 8'd13;
      opb = 8'd11;
      #1;
      chk("R8 product before next edge", int'(prod), 143);
      opa = 8'd200;
      #0.5;
      chk("R8 follows operand change", int'(prod), 2200);
      @(negedge clk);
   endtask

   task automatic t_sweep();
      int bad = 0;
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            apply(a, b);
            if (int'(prod) != a * b) begin
               bad++;
               if (bad <= 8) chk("R1 exhaustive", int'(prod), a * b);
            end
         end
      end
      chk("R1 exhaustive mismatches", bad, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      opa = '0;
      opb = '0;
      {cx1, cx2, cx3, cx4, ccin} = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_cell();
      t_zero();
      t_max();
      t_carry_runs();
      t_identity_shift();
      t_same_cycle();
      t_sweep();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule